// File: doc/BRIEF.md
# Cell Balancing Control Sequencer

This block drives the balance switch outputs for a stack of twelve series cells. Software programs it through a small register port with three words. The setup word holds a balance enable, a two-bit mode, a bank pointer and a wait code. A timing word holds a seven-bit balance timeout code. A banked status word reaches one of thirteen twelve-bit cell masks, and the pointer chooses which one a read or write touches. Two single-cycle command inputs set or clear the enable without a register write.

In manual mode the outputs copy mask 0 while the enable is set. Timed mode applies mask 0 for one timeout period and then finishes. Auto mode steps through masks 1 to 12 in order. Each mask is held for one timeout period, and an idle pause of the wait length separates consecutive masks. When a timed or auto run finishes, the enable clears by itself and an end-of-balance flag rises. Codes count abstract ticks: the timeout lasts `code * TO_UNIT` clock cycles and the wait lasts `code * WAIT_UNIT` cycles.

Top module: `cell_bal_seq`

## Requirements
- R1: After reset every field, every mask, the timeout code and all outputs read 0, and `eob_o` is 0.
- R2: The setup word (select 0) places the enable at bit 0, the mode at bits [2:1] (0 off, 1 manual, 2 timed, 3 auto), the pointer at bits [6:3] and the wait code at bits [9:7]. The timing word (select 1... see R3 for select 1) is select 2, with the timeout code at bits [6:0]. Every other bit reads 0.
- R3: Select 1 reads or writes mask bits [11:0] of the bank that the pointer names, with bit 0 for cell 1. A pointer of 13 or more reads 0, and writes to it change no bank. Select 3 reads 0.
- R4: In manual mode `bal_o` equals mask 0 while the enable is set, and is 0 while the enable is clear.
- R5: In off mode `bal_o` is 0 whatever the enable and the masks hold.
- R6: `cmd_en_i` sets the enable and `cmd_inh_i` clears it, and neither alters any other field. Inhibit takes priority over enable, and both take priority over a setup write.
- R7: In timed mode with a nonzero code T, the enable is set at edge e. `bal_o` is 0 after edge e, equals mask 0 after edges e+1 through e+T·TO_UNIT, and is 0 after that. At the following edge the enable clears and `eob_o` rises.
- R8: In timed mode with a timeout code of 0, mask 0 stays applied for as long as the enable is set, and `eob_o` never rises.
- R9: In auto mode, masks 1 to 12 are applied in order starting at edge e+1. Each is held for T·TO_UNIT cycles. Between consecutive masks, `bal_o` is 0 for W·WAIT_UNIT cycles, and there is no pause after mask 12. The run then ends as in R7.
- R10: In auto mode with a wait code of 0, each mask follows the previous one in the next cycle.
- R11: `eob_o` returns to 0 at the edge where the enable goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Write strobe for the selected word |
| reg_sel_i | input | 2 | Word select: 0 setup, 1 banked mask, 2 timing |
| reg_wdata_i | input | 14 | Write data |
| reg_rdata_o | output | 14 | Read data of the selected word (combinational) |
| cmd_en_i | input | 1 | Set-enable command pulse |
| cmd_inh_i | input | 1 | Clear-enable command pulse |
| bal_o | output | 12 | Balance switch drive, bit 0 is cell 1 |
| eob_o | output | 1 | End-of-balance flag |

## Verification
Manual mode is exercised with random mask 0 values and with the enable toggled both by register writes and by commands. This separates gating by enable from gating by mode. Timed runs use a nonzero code and a zero code, which shows whether expiry is counted and whether a zero code disables it. Auto runs use one nonzero wait and one zero wait, with each bank filled with a distinct random mask. The pattern on `bal_o` in every cycle then shows the order of the steps, the length of each hold, the presence of each pause, and the missing pause after the last step. Randomly filled banks are read back at all sixteen pointer values, so aliasing and out-of-range writes show up.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_MAN   = 2'd1,
    MODE_TIMED = 2'd2,
    MODE_AUTO  = 2'd3
  } bal_mode_e;

  typedef enum logic [1:0] {
    SEL_SETUP = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_TIME  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } seq_state_e;

  localparam int EN_POS   = 0;
  localparam int MODE_POS = 1;
  localparam int PTR_POS  = 3;

  // Number of clock cycles that a tick code stands for
  function automatic int unsigned span_ticks(input int unsigned code,
                                             input int unsigned unit);
    return code * unit;
  endfunction

endpackage

// File: rtl/cbs_regs.sv
module cbs_regs
  import cbs_pkg::*;
#(
  parameter int NCELL   = 12,
  parameter int NBANK   = 13,
  parameter int PTR_W   = 4,
  parameter int WCODE_W = 3,
  parameter int TCODE_W = 7,
  parameter int DW      = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_i,
  input  logic [1:0]                  reg_sel_i,
  input  logic [DW-1:0]               reg_wdata_i,
  output logic [DW-1:0]               reg_rdata_o,
  input  logic                        cmd_en_i,
  input  logic                        cmd_inh_i,
  input  logic                        seq_done_i,
  output logic                        en_o,
  output bal_mode_e                   mode_o,
  output logic [WCODE_W-1:0]          wcode_o,
  output logic [TCODE_W-1:0]          tcode_o,
  output logic [NBANK-1:0][NCELL-1:0] banks_o,
  output logic                        eob_o
);

  localparam int WAIT_POS = PTR_POS + PTR_W;

  logic               en_q, en_nxt;
  bal_mode_e          mode_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [WCODE_W-1:0] wcode_q;
  logic [TCODE_W-1:0] tcode_q;
  logic [NCELL-1:0]   bank_q [NBANK];
  logic [NCELL-1:0]   stat_rd;
  logic               setup_wr, stat_wr, time_wr;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign setup_wr = reg_wr_i && (reg_sel_i == SEL_SETUP);
  assign stat_wr  = reg_wr_i && (reg_sel_i == SEL_STAT);
  assign time_wr  = reg_wr_i && (reg_sel_i == SEL_TIME);

  // Enable priority: inhibit > enable command > write > completion
  always_comb begin
    en_nxt = en_q;
    if (seq_done_i) en_nxt = 1'b0;
    if (setup_wr)   en_nxt = reg_wdata_i[EN_POS];
    if (cmd_en_i)   en_nxt = 1'b1;
    if (cmd_inh_i)  en_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= MODE_OFF;
      ptr_q   <= '0;
      wcode_q <= '0;
      tcode_q <= '0;
      eob_o   <= 1'b0;
    end else begin
      en_q <= en_nxt;
      if (setup_wr) begin
        mode_q  <= bal_mode_e'(reg_wdata_i[MODE_POS +: 2]);
        ptr_q   <= reg_wdata_i[PTR_POS +: PTR_W];
        wcode_q <= reg_wdata_i[WAIT_POS +: WCODE_W];
      end
      if (time_wr) tcode_q <= reg_wdata_i[TCODE_W-1:0];
      if (en_nxt && !en_q)  eob_o <= 1'b0;
      else if (seq_done_i)  eob_o <= 1'b1;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bank_q[b] <= '0;
      else if (stat_wr && ptr_q == PTR_W'(b))      bank_q[b] <= reg_wdata_i[NCELL-1:0];
    end
    assign banks_o[b] = bank_q[b];
  end

  always_comb begin
    stat_rd = '0;
    for (int i = 0; i < NBANK; i++)
      if (ptr_q == PTR_W'(i)) stat_rd = bank_q[i];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_SETUP: begin
        reg_rdata_o[EN_POS]                = en_q;
        reg_rdata_o[MODE_POS +: 2]         = mode_q;
        reg_rdata_o[PTR_POS +: PTR_W]      = ptr_q;
        reg_rdata_o[WAIT_POS +: WCODE_W]   = wcode_q;
      end
      SEL_STAT: reg_rdata_o[NCELL-1:0]   = stat_rd;
      SEL_TIME: reg_rdata_o[TCODE_W-1:0] = tcode_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign mode_o  = mode_q;
  assign wcode_o = wcode_q;
  assign tcode_o = tcode_q;

  // R3: banks beyond the last one are invisible
  assert_ptr_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_i == SEL_STAT && ptr_q >= PTR_W'(NBANK)) |-> (reg_rdata_o == '0));

  // R6: inhibit command always leaves the enable clear
  assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_inh_i |=> !en_q);

endmodule

// File: rtl/cbs_seq.sv
module cbs_seq
  import cbs_pkg::*;
#(
  parameter int NBANK     = 13,
  parameter int PTR_W     = 4,
  parameter int WCODE_W   = 3,
  parameter int TCODE_W   = 7,
  parameter int TO_UNIT   = 4,
  parameter int WAIT_UNIT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  bal_mode_e          mode_i,
  input  logic [TCODE_W-1:0] tcode_i,
  input  logic [WCODE_W-1:0] wcode_i,
  output logic               run_o,
  output logic [PTR_W-1:0]   step_o,
  output logic               done_o
);

  localparam int TMAX  = ((1 << TCODE_W) - 1) * TO_UNIT;
  localparam int WMAX  = ((1 << WCODE_W) - 1) * WAIT_UNIT;
  localparam int LMAX  = (TMAX > WMAX) ? TMAX : WMAX;
  localparam int CNT_W = $clog2(LMAX + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBANK - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, t_len, w_len;
  logic [PTR_W-1:0] step_q;
  logic             active, t_exp, w_exp, last_step;

  assign t_len     = CNT_W'(span_ticks(32'(tcode_i), TO_UNIT));
  assign w_len     = CNT_W'(span_ticks(32'(wcode_i), WAIT_UNIT));
  assign active    = en_i && (mode_i == MODE_TIMED || mode_i == MODE_AUTO);
  assign t_exp     = (state_q == ST_RUN) && (t_len != '0) && (cnt_q == t_len - 1'b1);
  assign w_exp     = (state_q == ST_PAUSE) && (cnt_q == w_len - 1'b1);
  assign last_step = (mode_i == MODE_TIMED) || (step_q == LAST);
  assign done_o    = active && t_exp && last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      step_q  <= PTR_W'(1);
    end else if (!active) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      step_q  <= PTR_W'(1);
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          step_q  <= PTR_W'(1);
        end
        ST_RUN: begin
          if (t_exp) begin
            cnt_q <= '0;
            if (last_step)           state_q <= ST_IDLE;
            else if (w_len == '0)    step_q  <= step_q + 1'b1;
            else                     state_q <= ST_PAUSE;
          end else if (t_len != '0) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAUSE: begin
          if (w_exp) begin
            state_q <= ST_RUN;
            step_q  <= step_q + 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign step_o = step_q;

  // R9: an applied auto step always names one of the sequence banks
  assert_step_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (step_q >= PTR_W'(1) && step_q <= LAST));

  // R9: a pause is never entered with a zero wait length
  assert_pause_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSE) |-> (w_len != '0));

endmodule

// File: rtl/cbs_drive.sv
module cbs_drive
  import cbs_pkg::*;
#(
  parameter int NCELL = 12,
  parameter int NBANK = 13,
  parameter int PTR_W = 4
) (
  input  logic                        en_i,
  input  bal_mode_e                   mode_i,
  input  logic                        run_i,
  input  logic [PTR_W-1:0]            step_i,
  input  logic [NBANK-1:0][NCELL-1:0] banks_i,
  output logic [NCELL-1:0]            bal_o
);

  logic [NCELL-1:0] step_mask, mask;

  always_comb begin
    step_mask = '0;
    for (int i = 1; i < NBANK; i++)
      if (step_i == PTR_W'(i)) step_mask = banks_i[i];
  end

  always_comb begin
    case (mode_i)
      MODE_MAN:   mask = banks_i[0];
      MODE_TIMED: mask = run_i ? banks_i[0] : '0;
      MODE_AUTO:  mask = run_i ? step_mask  : '0;
      default:    mask = '0;
    endcase
    bal_o = en_i ? mask : '0;
  end

endmodule

// File: rtl/cell_bal_seq.sv
module cell_bal_seq
  import cbs_pkg::*;
#(
  parameter int NCELL     = 12,
  parameter int NBANK     = 13,
  parameter int WCODE_W   = 3,
  parameter int TCODE_W   = 7,
  parameter int TO_UNIT   = 4,
  parameter int WAIT_UNIT = 2,
  parameter int DW        = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             cmd_en_i,
  input  logic             cmd_inh_i,
  output logic [NCELL-1:0] bal_o,
  output logic             eob_o
);

  localparam int PTR_W = $clog2(NBANK);

  logic                        en_w, run_w, done_w, set_hi_w;
  bal_mode_e                   mode_w;
  logic [WCODE_W-1:0]          wcode_w;
  logic [TCODE_W-1:0]          tcode_w;
  logic [PTR_W-1:0]            step_w;
  logic [NBANK-1:0][NCELL-1:0] banks_w;

  cbs_regs #(.NCELL(NCELL), .NBANK(NBANK), .PTR_W(PTR_W), .WCODE_W(WCODE_W),
             .TCODE_W(TCODE_W), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .cmd_en_i(cmd_en_i),
    .cmd_inh_i(cmd_inh_i), .seq_done_i(done_w), .en_o(en_w), .mode_o(mode_w),
    .wcode_o(wcode_w), .tcode_o(tcode_w), .banks_o(banks_w), .eob_o(eob_o));

  cbs_seq #(.NBANK(NBANK), .PTR_W(PTR_W), .WCODE_W(WCODE_W), .TCODE_W(TCODE_W),
            .TO_UNIT(TO_UNIT), .WAIT_UNIT(WAIT_UNIT)) seq_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .mode_i(mode_w), .tcode_i(tcode_w),
    .wcode_i(wcode_w), .run_o(run_w), .step_o(step_w), .done_o(done_w));

  cbs_drive #(.NCELL(NCELL), .NBANK(NBANK), .PTR_W(PTR_W)) drive_i (
    .en_i(en_w), .mode_i(mode_w), .run_i(run_w), .step_i(step_w),
    .banks_i(banks_w), .bal_o(bal_o));

  assign set_hi_w = reg_wr_i && (reg_sel_i == SEL_SETUP) && reg_wdata_i[EN_POS];

  // R4: no cell is driven while the enable is clear
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |-> (bal_o == '0));

  // R5: off mode drives nothing
  assert_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_OFF) |-> (bal_o == '0));

  // R7: completion clears the enable and raises the flag
  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && !cmd_en_i && !set_hi_w) |=> (eob_o && !en_w));

  // R9: auto mode is silent outside an applied step
  assert_auto_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_AUTO && !run_w) |-> (bal_o == '0));

  // R11: a fresh enable leaves the flag clear
  assert_eob_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_w) |-> !eob_o);

endmodule

// File: tb/cell_bal_seq_tb_top.sv
module cell_bal_seq_tb_top;

  localparam int TO_UNIT   = 4;
  localparam int WAIT_UNIT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [13:0] reg_wdata = '0;
  logic [13:0] reg_rdata;
  logic        cmd_en = 1'b0;
  logic        cmd_inh = 1'b0;
  logic [11:0] bal;
  logic        eob;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] mbank [13];

  always #2 clk = ~clk;

  cell_bal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cmd_en_i(cmd_en),
    .cmd_inh_i(cmd_inh), .bal_o(bal), .eob_o(eob));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] setup_word(input logic en, input logic [1:0] mode,
                                             input logic [3:0] ptr, input logic [2:0] wc);
    return {4'b0, wc, ptr, mode, en};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [13:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [13:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [11:0] exp_auto(input int p, input int t, input int w);
    int q = p;
    if (q < 0) return '0;
    for (int s = 1; s <= 12; s++) begin
      if (q < t) return mbank[s];
      q -= t;
      if (s == 12) return '0;
      if (q < w) return '0;
      q -= w;
    end
    return '0;
  endfunction

  task automatic run_auto(input logic [6:0] tc, input logic [2:0] wc, input string tag);
    int t = int'(tc) * TO_UNIT;
    int w = int'(wc) * WAIT_UNIT;
    int total = 12 * t + 11 * w;
    int bad0 = n_bad;
    logic [13:0] d;
    wr(2'd2, {7'b0, tc});
    wr(2'd0, setup_word(1'b1, 2'd3, 4'd0, wc));
    for (int j = 0; j <= total + 1; j++) begin
      if (j > 0) @(negedge clk);
      chk(tag, bal, exp_auto(j - 1, t, w));
      chk({tag, " eob"}, eob, (j == total + 1));
    end
    rd(2'd0, d);
    chk({tag, " enable cleared"}, d[0], 1'b0);
    if (n_bad == bad0) $display("auto run %s ok", tag);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] d, sw;
    int unsigned seed = $urandom(32'd4711);
    for (int i = 0; i < 13; i++) mbank[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 bal", bal, 0);
    chk("R1 eob", eob, 0);
    rd(2'd0, d); chk("R1 setup", d, 0);
    rd(2'd2, d); chk("R1 timing", d, 0);
    for (int p = 0; p < 13; p++) begin
      wr(2'd0, setup_word(1'b0, 2'd0, 4'(p), 3'd0));
      rd(2'd1, d); chk("R1 bank", d, 0);
    end

    // R2: setup and timing layout, random values with enable kept off
    for (int i = 0; i < 8; i++) begin
      sw = setup_word(1'b0, 2'($urandom), 4'($urandom), 3'($urandom));
      wr(2'd0, sw | 14'h3C00);
      rd(2'd0, d); chk("R2 setup readback", d, sw);
      sw = 14'($urandom);
      wr(2'd2, sw);
      rd(2'd2, d); chk("R2 timing readback", d, {7'b0, sw[6:0]});
    end

    // R3: random bank writes through every pointer, then full readback
    for (int i = 0; i < 40; i++) begin
      int p = int'($urandom % 16);
      logic [13:0] v = 14'($urandom);
      wr(2'd0, setup_word(1'b0, 2'd0, 4'(p), 3'd0));
      wr(2'd1, v);
      if (p < 13) mbank[p] = v[11:0];
    end
    for (int p = 0; p < 16; p++) begin
      wr(2'd0, setup_word(1'b0, 2'd0, 4'(p), 3'd0));
      rd(2'd1, d); chk("R3 bank readback", d, (p < 13) ? {2'b0, mbank[p]} : 14'd0);
    end
    rd(2'd3, d); chk("R3 select 3", d, 0);
    // give every sequence bank a distinct nonzero mask
    for (int p = 0; p < 13; p++) begin
      mbank[p] = 12'($urandom) | 12'h001;
      mbank[p][11:8] = 4'(p);
      wr(2'd0, setup_word(1'b0, 2'd0, 4'(p), 3'd0));
      wr(2'd1, {2'b0, mbank[p]});
    end

    // R4: manual mode under random mask 0 values
    for (int i = 0; i < 6; i++) begin
      mbank[0] = 12'($urandom);
      wr(2'd0, setup_word(1'b0, 2'd1, 4'd0, 3'd0));
      wr(2'd1, {2'b0, mbank[0]});
      chk("R4 manual disabled", bal, 0);
      wr(2'd0, setup_word(1'b1, 2'd1, 4'd0, 3'd0));
      chk("R4 manual enabled", bal, mbank[0]);
    end

    // R5: off mode with enable set
    wr(2'd0, setup_word(1'b1, 2'd0, 4'd0, 3'd0));
    repeat (3) @(negedge clk);
    chk("R5 off mode", bal, 0);

    // R6: commands
    wr(2'd0, setup_word(1'b0, 2'd1, 4'd5, 3'd6));
    cmd_en = 1'b1; @(negedge clk); cmd_en = 1'b0;
    chk("R6 cmd enable output", bal, mbank[0]);
    rd(2'd0, d); chk("R6 cmd enable fields", d, setup_word(1'b1, 2'd1, 4'd5, 3'd6));
    cmd_inh = 1'b1; @(negedge clk); cmd_inh = 1'b0;
    chk("R6 cmd inhibit output", bal, 0);
    rd(2'd0, d); chk("R6 cmd inhibit fields", d, setup_word(1'b0, 2'd1, 4'd5, 3'd6));
    cmd_en = 1'b1; cmd_inh = 1'b1; @(negedge clk); cmd_en = 1'b0; cmd_inh = 1'b0;
    chk("R6 inhibit wins", bal, 0);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = setup_word(1'b0, 2'd1, 4'd5, 3'd6);
    cmd_en = 1'b1; @(negedge clk); reg_wr = 1'b0; cmd_en = 1'b0;
    rd(2'd0, d); chk("R6 command over write", d[0], 1'b1);
    wr(2'd0, setup_word(1'b0, 2'd0, 4'd0, 3'd0));

    // R7: timed run with code 3
    begin
      int t = 3 * TO_UNIT;
      wr(2'd2, 14'd3);
      wr(2'd0, setup_word(1'b1, 2'd2, 4'd0, 3'd0));
      for (int j = 0; j <= t + 1; j++) begin
        if (j > 0) @(negedge clk);
        chk("R7 timed output", bal, (j >= 1 && j <= t) ? mbank[0] : 12'd0);
        chk("R7 timed eob", eob, (j == t + 1));
      end
      rd(2'd0, d); chk("R7 enable cleared", d[0], 1'b0);
    end

    // R11: re-enabling clears the flag
    wr(2'd0, setup_word(1'b1, 2'd1, 4'd0, 3'd0));
    chk("R11 eob cleared", eob, 0);
    wr(2'd0, setup_word(1'b0, 2'd0, 4'd0, 3'd0));

    // R8: timeout code 0 never expires
    wr(2'd2, 14'd0);
    wr(2'd0, setup_word(1'b1, 2'd2, 4'd0, 3'd0));
    @(negedge clk);
    for (int j = 0; j < 700; j++) begin
      @(negedge clk);
      if (bal !== mbank[0] || eob !== 1'b0) begin
        chk("R8 held output", bal, mbank[0]);
        chk("R8 no eob", eob, 0);
      end
    end
    chk("R8 held output", bal, mbank[0]);
    chk("R8 no eob", eob, 0);
    wr(2'd0, setup_word(1'b0, 2'd0, 4'd0, 3'd0));

    // R9 and R10: auto sequences
    run_auto(7'd1, 3'd2, "R9 auto with wait");
    run_auto(7'd2, 3'd0, "R10 auto no wait");
    run_auto(7'($urandom % 4 + 1), 3'($urandom % 7 + 1), "R9 auto random");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule